// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers sixteen interrupt sources onto ten vectors and presents one request at a time to a processor core. Four sources are external pins and the other twelve are request lines from on-chip peripherals. Each vector has an enable bit and a priority-select bit. The selected priority is resolved into one of three service levels: low, high or highest. Only the two lowest-numbered pin vectors can reach the highest level.

The controller tracks which levels are currently being serviced. A new request is offered only when its level is strictly above the deepest level in service, so a higher level can preempt a lower one. The core answers through a simple handshake:

- An acknowledge pulse takes the offered request, pushes its level and clears its latched edge.
- A return pulse pops the highest level in service.

Each pin goes through a two-stage synchronizer and an edge detector. The trigger options differ between the two pin pairs.

Top module: `irq_prio_ctrl`

## Requirements
- R1: During and after synchronous reset, with no source active, `irq_req` is 0 and `svc_lvl` is 0.
- R2: The offered address is 03h + 8 × vector. Pin n maps to vector n, so pins 0..3 give 03h, 0Bh, 13h and 1Bh, and vector 9 gives 4Bh.
- R3: Level codes are 1 = low, 2 = high and 3 = highest. Vectors 0 and 1 take level 2 when `vec_hi` is 0 and level 3 when it is 1. Vectors 2..9 take level 1 when `vec_hi` is 0 and level 2 when it is 1. A request at level 3 always names vector 0 or 1.
- R4: Among pending, enabled vectors the highest level wins. At equal level the lower vector number wins.
- R5: A vector is offered only when its level is strictly greater than `svc_lvl`. A request at or below the level in service waits until that level is popped.
- R6: When `irq_ack` is high while `irq_req` is high, the offered level is pushed and `svc_lvl` takes it. `irq_req` is then low on the next cycle. Each `irq_reti` pulse removes the highest level in service. `irq_reti` with nothing in service leaves `svc_lvl` at 0.
- R7: Pins 0 and 1 use a 2-bit mode field: 00 = rising edge, 01 = falling edge, 10 = high level, 11 = low level. A level-mode request is pending only while the pin holds the active level, and it disappears without any acknowledge.
- R8: Pins 2 and 3 use a 2-bit mode field: 00 = rising edge, 01 = falling edge, 1x = both edges. Level triggering is not available on these pins, so a steady pin raises nothing.
- R9: An edge event is held in a flag until the acknowledge of its own vector clears it. The flag is not re-raised while the pin stays steady.
- R10: A vector with `vec_en` low is never offered. A latched edge flag survives while its vector is disabled and is offered once the vector is enabled.
- R11: Peripheral line i maps to a vector as follows: 0 → 2, 1 → 3, 2 → 4, 3 and 4 → 5, 5 → 6, 6 → 7, 7 to 9 → 8, 10 and 11 → 9. A line is pending while it is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 4 | Asynchronous external interrupt pins |
| ext_mode | input | 8 | Trigger mode, two bits per pin, pin n at bits 2n+1:2n |
| periph_req | input | 12 | Peripheral request lines, active high |
| vec_en | input | 10 | Per-vector enable |
| vec_hi | input | 10 | Per-vector upper-priority select |
| irq_ack | input | 1 | Core accepts the offered request |
| irq_reti | input | 1 | Core returns from the current service level |
| irq_req | output | 1 | Request offered to the core |
| irq_vec | output | 4 | Offered vector number |
| irq_addr | output | 8 | Offered vector address |
| irq_lvl | output | 2 | Level of the offered request |
| svc_lvl | output | 2 | Highest level currently in service |

## Verification
The bench targets ties at equal level. A design that scans in the wrong order would offer the higher-numbered vector.

It checks a pending request whose level equals the level in service. A non-strict compare would re-enter the same level immediately after acknowledge.

Nested service is popped twice, followed by a pop with nothing in service. A wrong pop would expose a lower level too early, or wrap the level in service.

Edge, level and both-edge modes are each driven on the matching pins. A design that treats a level like an edge would keep requesting after the pin drops. A design that clears flags on disable would lose the event that arrived while the vector was masked.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_EXT    = 4;
  localparam int NUM_PER    = 12;
  localparam int NUM_VEC    = 10;
  localparam int VEC_W      = $clog2(NUM_VEC);
  localparam int LVL_W      = 2;
  localparam int NUM_LVL    = (1 << LVL_W) - 1;
  localparam int VEC_BASE   = 3;
  localparam int VEC_STRIDE = 8;
  localparam int ADDR_W     = 8;
  localparam int TOP_EXT    = 2;   // pins that may reach the highest level

  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_LOW  = 2'd1;
  localparam lvl_t LVL_HIGH = 2'd2;
  localparam lvl_t LVL_TOP  = 2'd3;

  // Peripheral line to vector map (R11)
  function automatic int per_vec(input int idx);
    case (idx)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      3, 4:    return 5;
      5:       return 6;
      6:       return 7;
      7, 8, 9: return 8;
      default: return 9;
    endcase
  endfunction

  // Vector address (R2)
  function automatic logic [ADDR_W-1:0] vec_addr(input int v);
    return ADDR_W'(VEC_BASE + v * VEC_STRIDE);
  endfunction
endpackage

// File: rtl/irq_ext_trig.sv
module irq_ext_trig #(
  parameter int SYNC_STAGES = 2,
  parameter bit LEVEL_OK    = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] mode,
  input  logic       clr,
  output logic       pend
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, flag_q;
  logic s_now, rise, fall, edge_hit, is_level, level_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign s_now = sync_q[SYNC_STAGES-1];
  assign rise  = s_now & ~prev_q;
  assign fall  = ~s_now & prev_q;

  generate
    if (LEVEL_OK) begin : g_lvl_pin
      // R7: 00 rise, 01 fall, 10 high level, 11 low level
      assign edge_hit  = mode[1] ? 1'b0 : (mode[0] ? fall : rise);
      assign is_level  = mode[1];
      assign level_act = mode[0] ? ~s_now : s_now;
    end else begin : g_edge_pin
      // R8: 00 rise, 01 fall, 1x both edges
      assign edge_hit  = mode[1] ? (rise | fall) : (mode[0] ? fall : rise);
      assign is_level  = 1'b0;
      assign level_act = 1'b0;
    end
  endgenerate

  // R9: edge flag set wins over clear
  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (is_level) flag_q <= 1'b0;
    else if (edge_hit) flag_q <= 1'b1;
    else if (clr)      flag_q <= 1'b0;
  end

  assign pend = is_level ? level_act : flag_q;

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr && !is_level) |=> flag_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NUM_VEC-1:0]       pend,
  input  logic [NUM_VEC*LVL_W-1:0] vlvl,
  input  lvl_t                     cur_lvl,
  output logic                     hit,
  output logic [VEC_W-1:0]         sel_vec,
  output lvl_t                     sel_lvl
);
  // Downward scan with >= leaves the lowest index at the best level (R4)
  always_comb begin
    sel_lvl = LVL_NONE;
    sel_vec = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (pend[i] && vlvl[i*LVL_W +: LVL_W] != LVL_NONE &&
          vlvl[i*LVL_W +: LVL_W] >= sel_lvl) begin
        sel_lvl = vlvl[i*LVL_W +: LVL_W];
        sel_vec = VEC_W'(i);
      end
    end
    hit = sel_lvl > cur_lvl;  // R5: strictly above
  end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output lvl_t top_lvl
);
  // One bit per level; nesting is strictly increasing, so a mask holds the stack
  logic [NUM_LVL-1:0] mask_q, mask_n, top_oh;

  always_comb begin
    top_lvl = LVL_NONE;
    for (int k = 0; k < NUM_LVL; k++)
      if (mask_q[k]) top_lvl = LVL_W'(k + 1);
    top_oh = '0;
    if (top_lvl != LVL_NONE) top_oh[top_lvl - 1] = 1'b1;
    mask_n = mask_q;
    if (pop) mask_n = mask_n & ~top_oh;
    if (push && push_lvl != LVL_NONE) mask_n[push_lvl - 1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_n;
  end

  p_pop_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && mask_q == '0) |=> (mask_q == '0));
  p_push_above_r5: assert property (@(posedge clk) disable iff (rst)
    push |-> (push_lvl > top_lvl));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_EXT-1:0]   ext_pin,
  input  logic [2*NUM_EXT-1:0] ext_mode,
  input  logic [NUM_PER-1:0]   periph_req,
  input  logic [NUM_VEC-1:0]   vec_en,
  input  logic [NUM_VEC-1:0]   vec_hi,
  input  logic                 irq_ack,
  input  logic                 irq_reti,
  output logic                 irq_req,
  output logic [VEC_W-1:0]     irq_vec,
  output logic [ADDR_W-1:0]    irq_addr,
  output logic [LVL_W-1:0]     irq_lvl,
  output logic [LVL_W-1:0]     svc_lvl
);
  logic [NUM_EXT-1:0]       ext_pend;
  logic [NUM_VEC-1:0]       raw_pend, vec_pend;
  logic [NUM_VEC*LVL_W-1:0] vlvl;
  logic                     arb_hit, ack_fire;
  logic [VEC_W-1:0]         arb_vec;
  lvl_t                     arb_lvl, stk_top;
  logic                     req_q;
  logic [VEC_W-1:0]         vec_q;
  logic [ADDR_W-1:0]        addr_q;
  lvl_t                     lvl_q;

  assign ack_fire = irq_ack & req_q;

  generate
    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
      irq_ext_trig #(
        .SYNC_STAGES(SYNC_STAGES),
        .LEVEL_OK   (e < TOP_EXT)
      ) trig_i (
        .clk (clk),
        .rst (rst),
        .pin (ext_pin[e]),
        .mode(ext_mode[2*e +: 2]),
        .clr (ack_fire && vec_q == VEC_W'(e)),
        .pend(ext_pend[e])
      );
    end
    // R3: per-vector level from the select bit
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_lvl
      if (v < TOP_EXT) begin : g_top
        assign vlvl[v*LVL_W +: LVL_W] = vec_hi[v] ? LVL_TOP : LVL_HIGH;
      end else begin : g_low
        assign vlvl[v*LVL_W +: LVL_W] = vec_hi[v] ? LVL_HIGH : LVL_LOW;
      end
    end
  endgenerate

  // R11: source grouping
  always_comb begin
    raw_pend = '0;
    for (int e = 0; e < NUM_EXT; e++)
      raw_pend[e] = raw_pend[e] | ext_pend[e];
    for (int i = 0; i < NUM_PER; i++)
      raw_pend[VEC_W'(per_vec(i))] = raw_pend[VEC_W'(per_vec(i))] | periph_req[i];
    vec_pend = raw_pend & vec_en;   // R10
  end

  irq_arbiter arb_i (
    .pend   (vec_pend),
    .vlvl   (vlvl),
    .cur_lvl(stk_top),
    .hit    (arb_hit),
    .sel_vec(arb_vec),
    .sel_lvl(arb_lvl)
  );

  irq_svc_stack stk_i (
    .clk     (clk),
    .rst     (rst),
    .push    (ack_fire),
    .push_lvl(lvl_q),
    .pop     (irq_reti),
    .top_lvl (stk_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      vec_q  <= '0;
      addr_q <= '0;
      lvl_q  <= LVL_NONE;
    end else begin
      req_q  <= ack_fire ? 1'b0 : arb_hit;
      vec_q  <= arb_vec;
      addr_q <= vec_addr(int'(arb_vec));
      lvl_q  <= arb_lvl;
    end
  end

  assign irq_req  = req_q;
  assign irq_vec  = vec_q;
  assign irq_addr = addr_q;
  assign irq_lvl  = lvl_q;
  assign svc_lvl  = stk_top;

  p_req_above_svc_r5: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_lvl > svc_lvl));
  p_top_ext_only_r3: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_lvl == LVL_TOP) |-> (irq_vec < VEC_W'(TOP_EXT)));
  p_ack_drop_r6: assert property (@(posedge clk) disable iff (rst)
    ack_fire |=> !irq_req);
  p_push_lvl_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_fire && !irq_reti) |=> (svc_lvl == $past(irq_lvl)));
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic [3:0]  ext_pin;
  logic [7:0]  ext_mode;
  logic [11:0] periph_req;
  logic [9:0]  vec_en, vec_hi;
  logic        irq_ack, irq_reti, irq_req;
  logic [3:0]  irq_vec;
  logic [7:0]  irq_addr;
  logic [1:0]  irq_lvl, svc_lvl;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .ext_mode(ext_mode),
    .periph_req(periph_req), .vec_en(vec_en), .vec_hi(vec_hi),
    .irq_ack(irq_ack), .irq_reti(irq_reti), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_addr(irq_addr), .irq_lvl(irq_lvl), .svc_lvl(svc_lvl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic settle();
    cyc(6);
  endtask

  task automatic do_ack();
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0; settle();
  endtask

  task automatic do_reti();
    irq_reti = 1'b1; cyc(1); irq_reti = 1'b0; settle();
  endtask

  task automatic reset_dut();
    ext_pin = '0; ext_mode = '0; periph_req = '0;
    vec_en = '1; vec_hi = '0; irq_ack = 1'b0; irq_reti = 1'b0;
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(2);
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R1 req after reset", irq_req, 0);
    chk("R1 svc after reset", svc_lvl, 0);
  endtask

  task automatic t_basic();
    reset_dut();
    periph_req[5] = 1'b1; settle();
    chk("R11 line5 req", irq_req, 1);
    chk("R11 line5 vec", irq_vec, 6);
    chk("R2 vec6 addr", irq_addr, 'h33);
    chk("R3 vec6 low lvl", irq_lvl, 1);
    do_ack();
    chk("R6 push svc", svc_lvl, 1);
    chk("R5 same level held", irq_req, 0);
    do_reti();
    chk("R6 pop svc", svc_lvl, 0);
    chk("R5 offered after pop", irq_req, 1);
    periph_req[5] = 1'b0; settle();
    chk("R11 line released", irq_req, 0);
  endtask

  task automatic t_prio();
    reset_dut();
    periph_req[2] = 1'b1; periph_req[6] = 1'b1; settle();
    chk("R4 tie low wins", irq_vec, 4);
    vec_hi[7] = 1'b1; settle();
    chk("R4 higher level wins", irq_vec, 7);
    chk("R3 vec7 high lvl", irq_lvl, 2);
    vec_hi[4] = 1'b1; settle();
    chk("R4 tie at high", irq_vec, 4);
    vec_hi[0] = 1'b1; ext_mode[1:0] = 2'b10; ext_pin[0] = 1'b1; settle();
    chk("R3 vec0 top", irq_lvl, 3);
    chk("R2 vec0 addr", irq_addr, 'h03);
    vec_hi[0] = 1'b0; settle();
    chk("R3 vec0 high lvl", irq_lvl, 2);
    chk("R4 vec0 beats vec4", irq_vec, 0);
  endtask

  task automatic t_nest();
    reset_dut();
    periph_req[6] = 1'b1; vec_hi[7] = 1'b1; settle();
    do_ack();
    chk("R6 svc high", svc_lvl, 2);
    periph_req[2] = 1'b1; settle();
    chk("R5 low blocked", irq_req, 0);
    vec_hi[0] = 1'b1; ext_mode[1:0] = 2'b10; ext_pin[0] = 1'b1; settle();
    chk("R5 preempt req", irq_req, 1);
    chk("R5 preempt vec", irq_vec, 0);
    do_ack();
    chk("R6 svc top", svc_lvl, 3);
    chk("R6 req drops", irq_req, 0);
    ext_pin[0] = 1'b0;
    do_reti();
    chk("R6 pop to high", svc_lvl, 2);
    chk("R5 nothing above high", irq_req, 0);
    do_reti();
    chk("R6 pop to none", svc_lvl, 0);
    chk("R4 vec7 resumes", irq_vec, 7);
    do_reti();
    chk("R6 empty pop", svc_lvl, 0);
    chk("R6 empty pop req", irq_req, 1);
  endtask

  task automatic t_int01();
    reset_dut();
    ext_pin[0] = 1'b1; settle();
    chk("R7 rise req", irq_req, 1);
    chk("R2 pin0 addr", irq_addr, 'h03);
    do_ack();
    chk("R9 cleared by ack", irq_req, 0);
    do_reti();
    chk("R9 steady pin no new", irq_req, 0);
    ext_mode[1:0] = 2'b01; ext_pin[0] = 1'b0; settle();
    chk("R7 fall req", irq_req, 1);
    do_ack(); do_reti();
    chk("R9 fall cleared", irq_req, 0);
    ext_mode[1:0] = 2'b10; settle();
    chk("R7 high level idle", irq_req, 0);
    ext_pin[0] = 1'b1; settle();
    chk("R7 high level req", irq_req, 1);
    ext_pin[0] = 1'b0; settle();
    chk("R7 level gone", irq_req, 0);
    ext_mode[3:2] = 2'b11; ext_pin[1] = 1'b0; settle();
    chk("R7 low level req", irq_req, 1);
    chk("R2 pin1 addr", irq_addr, 'h0B);
    ext_pin[1] = 1'b1; settle();
    chk("R7 low level gone", irq_req, 0);
  endtask

  task automatic t_int23();
    reset_dut();
    ext_pin[2] = 1'b1; settle();
    chk("R8 pin2 rise", irq_req, 1);
    chk("R2 pin2 addr", irq_addr, 'h13);
    do_ack(); do_reti();
    ext_pin[2] = 1'b0; settle();
    chk("R8 rise ignores fall", irq_req, 0);
    ext_mode[7:6] = 2'b10; ext_pin[3] = 1'b1; settle();
    chk("R2 pin3 addr", irq_addr, 'h1B);
    do_ack(); do_reti();
    chk("R8 both steady", irq_req, 0);
    ext_pin[3] = 1'b0; settle();
    chk("R8 both fall", irq_req, 1);
    do_ack(); do_reti();
    ext_mode[5:4] = 2'b01; ext_pin[2] = 1'b1; settle();
    chk("R8 fall ignores rise", irq_req, 0);
    ext_pin[2] = 1'b0; settle();
    chk("R8 pin2 fall vec", irq_vec, 2);
    chk("R8 pin2 fall req", irq_req, 1);
  endtask

  task automatic t_enable();
    reset_dut();
    vec_en[3] = 1'b0; ext_pin[3] = 1'b1; settle();
    chk("R10 disabled", irq_req, 0);
    vec_en[3] = 1'b1; settle();
    chk("R10 kept flag", irq_req, 1);
    chk("R10 kept vec", irq_vec, 3);
  endtask

  task automatic t_shared();
    reset_dut();
    periph_req[9] = 1'b1; settle();
    chk("R11 line9 addr", irq_addr, 'h43);
    periph_req[9] = 1'b0; periph_req[11] = 1'b1; settle();
    chk("R11 line11 addr", irq_addr, 'h4B);
    periph_req[11] = 1'b0; periph_req[4] = 1'b1; settle();
    chk("R11 line4 addr", irq_addr, 'h2B);
    periph_req[4] = 1'b0; periph_req[0] = 1'b1; settle();
    chk("R11 line0 vec", irq_vec, 2);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_prio();
    t_nest();
    t_int01();
    t_int23();
    t_enable();
    t_shared();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule